// File: doc/BRIEF.md
# AES-128 Round Key Store

This block turns a 128-bit cipher key into the eleven AES-128 round keys a single time and then keeps them for as many data blocks as follow. A load strobe captures the key. The expansion then writes one round key per clock into an internal RAM. The incoming key (round key 0) and the final round key (round key 10) are also held in two dedicated 128-bit registers. This lets the first key addition of either direction use them at once, with no RAM read.

A round datapath uses the block in two ways. It takes the opening key from `first_key`, which follows the direction input. It then asks for the remaining keys by iteration number on a read port that answers one clock later. In the encrypt direction, iteration 1 to 10 returns round key 1 to 10. In the decrypt direction, iteration 1 to 10 returns round key 9 down to 0. No read is served until the whole schedule exists, so decryption cannot start early.

The controller has three states. KS_EMPTY holds after reset. KS_EXPAND is active while keys are being produced. KS_READY holds once the schedule is complete. The transitions are:
- LOAD goes from any state to KS_EXPAND, and from KS_EXPAND it restarts the expansion.
- STEP keeps the controller in KS_EXPAND while the counter is below 10.
- FINISH goes from KS_EXPAND to KS_READY after round key 10 is written.

Top module: `aes128_key_store`

## Requirements
- R1: After reset, `busy`, `ready` and `rd_valid` are all low.
- R2: A `key_load` pulse sets `busy` in the next cycle. `busy` stays high for exactly 10 cycles, and then `ready` rises while `busy` falls.
- R3: Round key i (1..10) is formed from key i-1 as follows. The last word (bits 31:0) is rotated left by one byte. Each byte is replaced by the AES S-box value. The top byte is XORed with the round constant (01,02,04,08,10,20,40,80,1B,36 for i=1..10). The result is then XORed word by word in a running chain from bits 127:96 downward. The published example key 2b7e151628aed2a6abf7158809cf4f3c gives round key 1 a0fafe1788542cb123a339392a6c7605 and round key 10 d014f9a8c9ee2589e13f0cc8b6630ca6.
- R4: While `ready` is high, `first_key` equals round key 0 when `mode`=0 (encrypt) and round key 10 when `mode`=1 (decrypt).
- R5: With `mode`=0, a read of iteration r in 1..10 while `ready` sets `rd_valid` in the next cycle and returns round key r on `rd_key`.
- R6: With `mode`=1, a read of iteration r in 1..10 while `ready` returns round key 10-r one cycle later with `rd_valid`.
- R7: A read made while `ready` is low, or with an iteration of 0 or above 10, leaves `rd_valid` low in the next cycle.
- R8: A `key_load` during `busy` drops the running expansion. The new key is expanded, and `busy` lasts 10 cycles counted from the new strobe.
- R9: A `key_load` while `ready` lowers `ready` in the next cycle and replaces the whole schedule with that of the new key.
- R10: The stored keys do not change under any number of reads until a new key is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Strobe: capture `key_in` and start expansion |
| key_in | input | 128 | Cipher key |
| mode | input | 1 | Direction: 0 encrypt, 1 decrypt |
| busy | output | 1 | Expansion in progress |
| ready | output | 1 | Full schedule stored |
| first_key | output | 128 | Round key 0 (encrypt) or round key 10 (decrypt) |
| rd_en | input | 1 | Read request |
| rd_round | input | 4 | Iteration number 1..10 |
| rd_valid | output | 1 | `rd_key` answers the previous cycle's request |
| rd_key | output | 128 | Round key read from the store |

## Verification
The assertions rely on `key_load` being a single-cycle strobe that is never sampled as unknown. They also assume that `mode` is held steady during any stretch where `first_key` is expected to be constant. The stimulus changes inputs just after the rising edge. It raises `key_load` for one cycle only, and it changes `mode` only between read bursts. Reads that overlap a load are confined to the encrypt direction, so no read and no write target the same RAM entry in one cycle.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

    typedef enum logic [1:0] {
        KS_EMPTY  = 2'd0,
        KS_EXPAND = 2'd1,
        KS_READY  = 2'd2
    } ks_state_t;

    // multiply by x in GF(2^8) with the AES reduction polynomial
    function automatic logic [7:0] gf_x2(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (8'h1b & {8{b[7]}});
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    // S-box: inverse as x^254 by square and multiply, then the affine map
    function automatic logic [7:0] sub_byte(input logic [7:0] x);
        logic [7:0] pw;
        logic [7:0] inv;
        pw  = x;
        inv = 8'h01;
        for (int i = 1; i < 8; i++) begin
            pw  = gf_mul(pw, pw);
            inv = gf_mul(inv, pw);
        end
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                   ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] round_const(input int rnd);
        logic [7:0] rc;
        rc = 8'h01;
        for (int i = 1; i < 16; i++) begin
            if (i < rnd) rc = gf_x2(rc);
        end
        return rc;
    endfunction

endpackage

// File: rtl/aes_ks_step.sv
module aes_ks_step #(
    parameter int NR   = 10,
    parameter int KW   = 128,
    parameter int AW   = 4
) (
    input  logic [KW-1:0] prev_key,
    input  logic [AW-1:0] rnd,
    output logic [KW-1:0] next_key
);
    import aes_ks_pkg::*;

    localparam int WORDS = KW / 32;

    logic [31:0] last_w;
    logic [31:0] rot_w;
    logic [31:0] mix_w;
    logic [31:0] chain [WORDS];

    assign last_w = prev_key[31:0];
    assign rot_w  = {last_w[23:0], last_w[31:24]};

    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_sub
            assign mix_w[8*g +: 8] = sub_byte(rot_w[8*g +: 8]);
        end
    endgenerate

    logic [31:0] temp_w;
    assign temp_w = mix_w ^ {round_const(int'(rnd)), 24'h000000};

    generate
        for (g = 0; g < WORDS; g++) begin : g_chain
            if (g == 0) begin : g_first
                assign chain[g] = prev_key[KW-1 -: 32] ^ temp_w;
            end else begin : g_rest
                assign chain[g] = prev_key[KW-1-32*g -: 32] ^ chain[g-1];
            end
            assign next_key[KW-1-32*g -: 32] = chain[g];
        end
    endgenerate

endmodule

// File: rtl/aes_ks_ram.sv
module aes_ks_ram #(
    parameter int W     = 128,
    parameter int DEPTH = 11,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (we) assert_waddr_range_R3 : assert (int'(waddr) < DEPTH)
            else $error("write address out of range");
        if (re) assert_raddr_range_R5 : assert (int'(raddr) < DEPTH)
            else $error("read address out of range");
    end

endmodule

// File: rtl/aes_ks_ctrl.sv
module aes_ks_ctrl #(
    parameter int NR = 10,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_load,
    output logic          busy,
    output logic          ready,
    output logic [AW-1:0] rnd,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          wr_from_input,
    output logic          advance,
    output logic          capture_last
);
    import aes_ks_pkg::*;

    localparam logic [AW-1:0] LAST  = AW'(NR);
    localparam logic [AW-1:0] FIRST = AW'(1);

    ks_state_t state, state_nx;
    logic [AW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            KS_EMPTY: begin
                if (key_load) begin
                    state_nx = KS_EXPAND;
                    cnt_nx   = FIRST;
                end
            end
            KS_EXPAND: begin
                if (key_load) begin
                    cnt_nx = FIRST;
                end else if (cnt == LAST) begin
                    state_nx = KS_READY;
                end else begin
                    cnt_nx = cnt + FIRST;
                end
            end
            KS_READY: begin
                if (key_load) begin
                    state_nx = KS_EXPAND;
                    cnt_nx   = FIRST;
                end
            end
            default: begin
                state_nx = KS_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= KS_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        busy          = (state == KS_EXPAND);
        ready         = (state == KS_READY);
        rnd           = cnt;
        wr_from_input = key_load;
        wr_en         = key_load || (state == KS_EXPAND);
        wr_addr       = key_load ? '0 : cnt;
        advance       = (state == KS_EXPAND) && !key_load;
        capture_last  = (state == KS_EXPAND) && !key_load && (cnt == LAST);
    end

    assert_busy_after_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> busy);

    assert_expand_ends_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rnd == LAST && !key_load) |=> (ready && !busy));

    assert_count_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd >= FIRST && rnd <= LAST));

    assert_ready_from_busy_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(busy));

endmodule

// File: rtl/aes_ks_reader.sv
module aes_ks_reader #(
    parameter int NR = 10,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_round,
    input  logic          mode,
    input  logic          ready,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    output logic          rd_valid
);
    localparam logic [AW-1:0] LAST = AW'(NR);

    logic in_range;

    always_comb begin
        in_range  = (rd_round != '0) && (rd_round <= LAST);
        ram_re    = rd_en && ready && in_range;
        ram_raddr = mode ? (LAST - rd_round) : rd_round;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= ram_re;
    end

    assert_valid_needs_ready_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(ready));

    assert_valid_needs_request_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

endmodule

// File: rtl/aes128_key_store.sv
module aes128_key_store #(
    parameter int NR    = 10,
    parameter int KEY_W = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          key_load,
    input  logic [KEY_W-1:0]              key_in,
    input  logic                          mode,
    output logic                          busy,
    output logic                          ready,
    output logic [KEY_W-1:0]              first_key,
    input  logic                          rd_en,
    input  logic [$clog2(NR+1)-1:0]       rd_round,
    output logic                          rd_valid,
    output logic [KEY_W-1:0]              rd_key
);
    localparam int AW    = $clog2(NR + 1);
    localparam int DEPTH = NR + 1;

    logic [AW-1:0]    rnd;
    logic             wr_en, wr_from_input, advance, capture_last;
    logic [AW-1:0]    wr_addr;
    logic [KEY_W-1:0] work_key, next_key, wdata;
    logic [KEY_W-1:0] key_first_q, key_last_q;
    logic             ram_re;
    logic [AW-1:0]    ram_raddr;

    aes_ks_ctrl #(.NR(NR), .AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_load     (key_load),
        .busy         (busy),
        .ready        (ready),
        .rnd          (rnd),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_from_input(wr_from_input),
        .advance      (advance),
        .capture_last (capture_last)
    );

    aes_ks_step #(.NR(NR), .KW(KEY_W), .AW(AW)) u_step (
        .prev_key(work_key),
        .rnd     (rnd),
        .next_key(next_key)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_key    <= '0;
            key_first_q <= '0;
            key_last_q  <= '0;
        end else begin
            if (key_load) begin
                work_key    <= key_in;
                key_first_q <= key_in;
            end else if (advance) begin
                work_key    <= next_key;
            end
            if (capture_last) key_last_q <= next_key;
        end
    end

    assign wdata     = wr_from_input ? key_in : next_key;
    assign first_key = mode ? key_last_q : key_first_q;

    aes_ks_ram #(.W(KEY_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk  (clk),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wdata),
        .re   (ram_re),
        .raddr(ram_raddr),
        .rdata(rd_key)
    );

    aes_ks_reader #(.NR(NR), .AW(AW)) u_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_round (rd_round),
        .mode     (mode),
        .ready    (ready),
        .ram_re   (ram_re),
        .ram_raddr(ram_raddr),
        .rd_valid (rd_valid)
    );

    assert_first_key_stable_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && $stable(mode)) |-> $stable(first_key));

    assert_load_drops_ready_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (ready && key_load) |=> !ready);

endmodule

// File: tb/aes128_key_store_test.sv
`timescale 1ns/1ps
module aes128_key_store_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [127:0] key_in = '0;
    logic         mode = 1'b0;
    logic         rd_en = 1'b0;
    logic [3:0]   rd_round = '0;
    logic         busy, ready, rd_valid;
    logic [127:0] first_key, rd_key;

    always #10 clk = ~clk;

    aes128_key_store uut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .mode(mode), .busy(busy), .ready(ready), .first_key(first_key),
        .rd_en(rd_en), .rd_round(rd_round), .rd_valid(rd_valid), .rd_key(rd_key)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] sb [256];

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv, s;
            inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
            sb[x] = s;
        end
    end

    function automatic logic [127:0] model_next(input logic [127:0] k, input int rnd);
        logic [31:0] w [4];
        logic [31:0] t;
        logic [7:0]  rc;
        rc = 8'h01;
        for (int i = 1; i < rnd; i++) rc = bmul(rc, 8'h02);
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        t = {sb[w[3][23:16]], sb[w[3][15:8]], sb[w[3][7:0]], sb[w[3][31:24]]};
        t[31:24] = t[31:24] ^ rc;
        w[0] = w[0] ^ t;
        w[1] = w[1] ^ w[0];
        w[2] = w[2] ^ w[1];
        w[3] = w[3] ^ w[2];
        return {w[0], w[1], w[2], w[3]};
    endfunction

    int           m_state = 0;   // 0 empty, 1 expanding, 2 ready
    int           m_cnt = 0;
    logic [127:0] m_keys [11];
    logic         m_rdv = 1'b0;
    logic [127:0] m_rdk = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_rdv = 1'b0;
        end else begin
            m_rdv = rd_en && m_state == 2 && rd_round >= 1 && rd_round <= 10;
            if (m_rdv) m_rdk = m_keys[mode ? 10 - int'(rd_round) : int'(rd_round)];
            if (key_load) begin
                m_keys[0] = key_in; m_cnt = 1; m_state = 1;
            end else if (m_state == 1) begin
                m_keys[m_cnt] = model_next(m_keys[m_cnt-1], m_cnt);
                if (m_cnt == 10) m_state = 2; else m_cnt++;
            end
        end
    end

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " busy"},  {127'd0, busy},  {127'd0, m_state == 1});
            check({cur_req, " ready"}, {127'd0, ready}, {127'd0, m_state == 2});
            check({cur_req, " rd_valid"}, {127'd0, rd_valid}, {127'd0, m_rdv});
            if (m_rdv) check({cur_req, " rd_key"}, rd_key, m_rdk);
            if (m_state == 2)
                check("R4 first_key", first_key, mode ? m_keys[10] : m_keys[0]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(); @(posedge clk); #1; endtask

    task automatic load(input logic [127:0] k);
        key_in = k; key_load = 1'b1; tick(); key_load = 1'b0;
    endtask

    task automatic read(input int r);
        rd_en = 1'b1; rd_round = 4'(r); tick(); rd_en = 1'b0;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!ready && n < 40) begin tick(); n++; end
    endtask

    initial begin
        repeat (3) tick();
        @(negedge clk);
        cur_req = "R1";
        check("R1 busy", {127'd0, busy}, '0);
        check("R1 ready", {127'd0, ready}, '0);
        check("R1 rd_valid", {127'd0, rd_valid}, '0);
        rst_n = 1'b1;
        tick();

        // expansion timing and read during busy
        cur_req = "R2";
        load(128'h2b7e151628aed2a6abf7158809cf4f3c);
        for (int i = 0; i < 10; i++) begin
            cur_req = "R7";
            rd_en = 1'b1; rd_round = 4'd1;
            check("R2 busy length", {127'd0, busy}, 128'd1);
            tick();
        end
        rd_en = 1'b0;
        check("R2 ready after 10", {127'd0, ready}, 128'd1);

        // published example values
        cur_req = "R3";
        mode = 1'b0;
        check("R3 key0 via first_key", first_key, 128'h2b7e151628aed2a6abf7158809cf4f3c);
        read(1);
        @(negedge clk);
        check("R3 round key 1", rd_key, 128'ha0fafe1788542cb123a339392a6c7605);
        tick();
        mode = 1'b1; tick();
        check("R3 round key 10", first_key, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

        cur_req = "R5";
        mode = 1'b0;
        for (int r = 1; r <= 10; r++) read(r);
        cur_req = "R7";
        read(0); read(11); read(15);
        cur_req = "R6";
        mode = 1'b1; tick();
        for (int r = 1; r <= 10; r++) read(r);
        cur_req = "R10";
        for (int p = 0; p < 3; p++)
            for (int r = 10; r >= 1; r--) read(r);
        mode = 1'b0; tick();
        for (int r = 1; r <= 10; r++) read(r);

        // restart while busy
        cur_req = "R8";
        load(128'h000102030405060708090a0b0c0d0e0f);
        repeat (4) tick();
        load(128'hffeeddccbbaa99887766554433221100);
        for (int i = 0; i < 10; i++) begin
            check("R8 busy after restart", {127'd0, busy}, 128'd1);
            tick();
        end
        check("R8 ready", {127'd0, ready}, 128'd1);
        for (int r = 1; r <= 10; r++) read(r);
        mode = 1'b1; tick();
        for (int r = 1; r <= 10; r++) read(r);

        // reload from ready, with an encrypt read in the same cycle
        cur_req = "R9";
        mode = 1'b0; tick();
        rd_en = 1'b1; rd_round = 4'd5;
        load(128'h00000000000000000000000000000000);
        rd_en = 1'b0;
        check("R9 ready dropped", {127'd0, ready}, '0);
        wait_ready();
        for (int r = 1; r <= 10; r++) read(r);
        mode = 1'b1; tick();
        for (int r = 1; r <= 10; r++) read(r);
        repeat (3) tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule